// File: doc/BRIEF.md
# Converter Control Mode Selector

This block is the control front end of a data converter. It decides where the converter's configuration comes from. After reset it is in pin mode. In pin mode the chip-select, data and clock lines of the serial port are read as static levels. Together with the power-down and output-enable pins, they set the operating mode, the output high-impedance state, the output standard and the data format.

Chip-select is the mode selector. The first falling edge it shows moves the block into serial mode, and the block stays there until reset. At that same edge the level on the data line is latched as the output standard for as long as serial mode lasts. In serial mode the operating mode, the high-impedance request and the data format come from a small configuration register. That register is loaded through a simple write port, which stands in for the serial register decoder. The converter core and the output drivers are not part of this block.

All pin inputs pass through a two-flop synchronizer before they are used. The synchronizer flops reset to the idle level of each line: chip-select resets high, all other lines reset low. As a result, a chip-select that is held low across the release of reset counts as a falling edge.

Top module: `conv_ctrl_select`

## Requirements
- R1: While reset (`rst_n` low, sampled on the clock) is applied and right after it, `serial_mode` is 0, so the block is in pin mode.
- R2: In pin mode, {`pin_pwd`,`pin_oe`} drive `op_mode` and `out_hiz` as follows. 00 gives `op_mode`=00 (run) with `out_hiz`=0. 01 gives run with `out_hiz`=1. 10 gives sleep (`op_mode`=01) with `out_hiz`=1. 11 gives power-down (`op_mode`=10) with `out_hiz`=1. The outputs follow a pin change within 2 clock edges.
- R3: In pin mode, `out_std` follows `pin_sdata`: 1 selects LVDS DDR and 0 selects CMOS.
- R4: In pin mode, `data_fmt` follows `pin_sclk`: 1 selects two's complement and 0 selects offset binary.
- R5: A falling edge on `pin_csel` sets `serial_mode` to 1 on the third clock edge after the pin falls. While `pin_csel` stays high, the block stays in pin mode.
- R6: Once `serial_mode` is 1, it stays 1 through any further chip-select activity until reset.
- R7: In serial mode, `out_std` holds the level that `pin_sdata` had at the switching edge. Later changes on `pin_sdata` and register writes do not change it.
- R8: Register writes made while in pin mode change no output and are not kept. After the switch, the register shows its reset contents.
- R9: In serial mode, a write with `reg_wr_en`=1 and `reg_wr_addr`=CFG_ADDR (0) takes effect one edge later. Data bits [1:0] select the mode (00 run, 01 sleep, 10 power-down, 11 is treated as power-down). Bit 2 requests high-Z. Bit 3 selects two's complement. `out_hiz` is the request OR any mode other than run. A write to any other address is ignored.
- R10: After reset, the configuration register holds run, no high-Z request and offset binary.
- R11: Applying reset while in serial mode returns the block to pin mode, and the outputs then follow the pins again.
- R12: In serial mode, `pin_pwd`, `pin_oe` and `pin_sclk` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset / power-down; returns the block to pin mode |
| pin_csel | input | 1 | Chip-select line, idle high; its first falling edge selects serial mode |
| pin_sdata | input | 1 | Serial data line; in pin mode, selects the output standard |
| pin_sclk | input | 1 | Serial clock line; in pin mode, selects the data format |
| pin_pwd | input | 1 | Power-down pin (pin mode only) |
| pin_oe | input | 1 | Output-enable pin (pin mode only) |
| reg_wr_en | input | 1 | Configuration register write strobe |
| reg_wr_addr | input | ADDR_W | Register write address |
| reg_wr_data | input | 4 | Register write data (fields as in R9) |
| op_mode | output | 2 | Operating mode: 00 run, 01 sleep, 10 power-down |
| out_hiz | output | 1 | Output drivers in high impedance |
| out_std | output | 1 | 1 = LVDS DDR, 0 = CMOS |
| data_fmt | output | 1 | 1 = two's complement, 0 = offset binary |
| serial_mode | output | 1 | 1 once serial control mode is active |

## Verification
The pin decoder is driven with every power-down/output-enable combination. The data and clock pins are set high one at a time and together. This separates the mode decode from the high-impedance decode and shows that the standard and format come from the correct pins. The mode switch is tested twice, once with the data pin high and once with it low, so a latch that is stuck at one value is caught. The exact edge on which the mode changes is also checked. Serial-mode writes run through each mode code, the high-Z bit, the format bit and a wrong address. Pin stimulus is applied both before the switch (writes ignored) and after it (pins ignored), which tells the two sources apart.

// File: rtl/cvs_pkg.sv
// Package: shared types and field positions for the converter control selector.
// Assumes: the configuration register is 4 bits wide, with fields as listed below.
package cvs_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_SLEEP = 2'b01,
        MODE_OFF   = 2'b10
    } op_mode_e;

    typedef struct packed {
        op_mode_e mode;
        logic     hiz;
        logic     fmt;
    } ctrl_t;

    localparam int CFG_W       = 4;
    localparam int F_MODE_LO   = 0;
    localparam int F_HIZ       = 2;
    localparam int F_FMT       = 3;

    localparam int SYNC_W      = 5;
    // Bit positions of the lines inside the synchronized pin vector.
    localparam int IX_OE       = 0;
    localparam int IX_PWD      = 1;
    localparam int IX_SCLK     = 2;
    localparam int IX_SDATA    = 3;
    localparam int IX_CSEL     = 4;

endpackage

// File: rtl/cvs_sync.sv
// Module: cvs_sync
// Brings a vector of asynchronous pin levels into the clock domain through a
// chain of STAGES flops for each bit. Each bit resets to its bit of RST_VAL.
// Assumes: the inputs are quasi-static levels, so per-bit skew is acceptable.
module cvs_sync #(
    parameter int             W       = 5,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: first stage samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Purpose: later stages settle any metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/cvs_mode_latch.sv
// Module: cvs_mode_latch
// Finds the first falling edge of the synchronized chip-select and sets a
// sticky serial-mode flag on it. At that same edge it captures the data line
// as the output standard.
// Assumes: cs_sync and sdata_sync come from the same synchronizer, so they
// are aligned in time.
module cvs_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_sync,
    input  logic sdata_sync,
    output logic serial_mode,
    output logic std_latched
);

    logic cs_prev;
    logic cs_fall;

    // Purpose: remember last cycle's chip-select level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_prev <= 1'b1;
        else        cs_prev <= cs_sync;
    end

    assign cs_fall = cs_prev & ~cs_sync;

    // Purpose: one-way switch into serial mode with capture of the standard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serial_mode <= 1'b0;
            std_latched <= 1'b0;
        end else if (!serial_mode && cs_fall) begin
            serial_mode <= 1'b1;
            std_latched <= sdata_sync;
        end
    end

    // R6: serial mode is never left without reset.
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        serial_mode |=> serial_mode);

    // R5: a falling chip-select seen in pin mode enters serial mode next edge.
    p_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!serial_mode && cs_prev && !cs_sync) |=> serial_mode);

    // R7: the latched standard is frozen while in serial mode.
    p_std_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        serial_mode |=> $stable(std_latched));

    // R7: the capture takes the data line level from the switching edge.
    p_std_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!serial_mode && cs_prev && !cs_sync) |=> (std_latched == $past(sdata_sync)));

endmodule

// File: rtl/cvs_pin_decode.sv
// Module: cvs_pin_decode
// Turns the synchronized static pins into the controls used in pin mode.
// Assumes: purely combinational; the inputs are already synchronized.
module cvs_pin_decode
    import cvs_pkg::*;
(
    input  logic  pwd,
    input  logic  oe,
    input  logic  sclk,
    output ctrl_t ctrl
);

    // Purpose: apply the power-down/output-enable table and the format pin.
    always_comb begin
        ctrl.fmt = sclk;
        unique case ({pwd, oe})
            2'b00: begin ctrl.mode = MODE_RUN;   ctrl.hiz = 1'b0; end
            2'b01: begin ctrl.mode = MODE_RUN;   ctrl.hiz = 1'b1; end
            2'b10: begin ctrl.mode = MODE_SLEEP; ctrl.hiz = 1'b1; end
            default: begin ctrl.mode = MODE_OFF; ctrl.hiz = 1'b1; end
        endcase
    end

    // R2: only the both-low combination drives the outputs.
    always_comb begin
        if (!ctrl.hiz) p_pin_drive_r2: assert ({pwd, oe} == 2'b00);
    end

endmodule

// File: rtl/cvs_serial_reg.sv
// Module: cvs_serial_reg
// Configuration register used in serial mode. It takes writes only while
// serial mode is active and only at CFG_ADDR. Mode code 11 is stored as
// power-down.
// Assumes: one write at most per cycle; takes effect on the next edge.
module cvs_serial_reg
    import cvs_pkg::*;
#(
    parameter int               ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    output ctrl_t             ctrl
);

    op_mode_e mode_q;
    logic     hiz_req_q;
    logic     fmt_q;
    logic     wr_hit;
    op_mode_e mode_in;

    assign wr_hit = wr_en && serial_mode && (wr_addr == CFG_ADDR);

    // Purpose: map the 2-bit mode field, folding the spare code into power-down.
    always_comb begin
        unique case (wr_data[F_MODE_LO +: 2])
            2'b00:   mode_in = MODE_RUN;
            2'b01:   mode_in = MODE_SLEEP;
            default: mode_in = MODE_OFF;
        endcase
    end

    // Purpose: hold the configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_RUN;
            hiz_req_q <= 1'b0;
            fmt_q     <= 1'b0;
        end else if (wr_hit) begin
            mode_q    <= mode_in;
            hiz_req_q <= wr_data[F_HIZ];
            fmt_q     <= wr_data[F_FMT];
        end
    end

    // Purpose: high-Z whenever requested or the converter is not running.
    always_comb begin
        ctrl.mode = mode_q;
        ctrl.fmt  = fmt_q;
        ctrl.hiz  = hiz_req_q | (mode_q != MODE_RUN);
    end

    // R8/R10: on entry to serial mode the register still has reset contents.
    p_clean_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(serial_mode) |-> (mode_q == MODE_RUN && !hiz_req_q && !fmt_q));

    // R9: a write that misses the address leaves the register unchanged.
    p_addr_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != CFG_ADDR) |=> ($stable(mode_q) && $stable(hiz_req_q) && $stable(fmt_q)));

endmodule

// File: rtl/conv_ctrl_select.sv
// Module: conv_ctrl_select (top)
// Control front end of a data converter. It synchronizes the pins, picks pin
// or serial control and drives the resolved operating controls.
// Assumes: rst_n is synchronous and also acts as the power-down that leaves
// serial mode.
module conv_ctrl_select
    import cvs_pkg::*;
#(
    parameter int               ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR    = '0,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_csel,
    input  logic              pin_sdata,
    input  logic              pin_sclk,
    input  logic              pin_pwd,
    input  logic              pin_oe,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [CFG_W-1:0]  reg_wr_data,
    output logic [1:0]        op_mode,
    output logic              out_hiz,
    output logic              out_std,
    output logic              data_fmt,
    output logic              serial_mode
);

    localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << IX_CSEL;

    logic [SYNC_W-1:0] pins_raw;
    logic [SYNC_W-1:0] pins_s;
    logic              std_latched;
    ctrl_t             pin_ctrl;
    ctrl_t             reg_ctrl;
    ctrl_t             sel_ctrl;

    always_comb begin
        pins_raw           = '0;
        pins_raw[IX_OE]    = pin_oe;
        pins_raw[IX_PWD]   = pin_pwd;
        pins_raw[IX_SCLK]  = pin_sclk;
        pins_raw[IX_SDATA] = pin_sdata;
        pins_raw[IX_CSEL]  = pin_csel;
    end

    cvs_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pins_raw),
        .q_sync  (pins_s)
    );

    cvs_mode_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_sync     (pins_s[IX_CSEL]),
        .sdata_sync  (pins_s[IX_SDATA]),
        .serial_mode (serial_mode),
        .std_latched (std_latched)
    );

    cvs_pin_decode u_pins (
        .pwd  (pins_s[IX_PWD]),
        .oe   (pins_s[IX_OE]),
        .sclk (pins_s[IX_SCLK]),
        .ctrl (pin_ctrl)
    );

    cvs_serial_reg #(
        .ADDR_W   (ADDR_W),
        .CFG_ADDR (CFG_ADDR)
    ) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .serial_mode (serial_mode),
        .wr_en       (reg_wr_en),
        .wr_addr     (reg_wr_addr),
        .wr_data     (reg_wr_data),
        .ctrl        (reg_ctrl)
    );

    // Purpose: choose the control source and the output standard.
    always_comb begin
        sel_ctrl = serial_mode ? reg_ctrl : pin_ctrl;
        out_std  = serial_mode ? std_latched : pins_s[IX_SDATA];
    end

    assign op_mode  = sel_ctrl.mode;
    assign out_hiz  = sel_ctrl.hiz;
    assign data_fmt = sel_ctrl.fmt;

    // R2/R9: a converter that is not running never drives its outputs.
    p_hiz_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode != MODE_RUN) |-> out_hiz);

    // R9: the spare mode code never reaches the output.
    p_mode_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_mode != 2'b11);

    // R1: the cycle after reset, the block is in pin mode.
    p_reset_pin_r1: assert property (@(posedge clk)
        !rst_n |=> !serial_mode);

endmodule

// File: tb/conv_ctrl_select_test.sv
module conv_ctrl_select_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pin_csel, pin_sdata, pin_sclk, pin_pwd, pin_oe;
    logic       reg_wr_en;
    logic [3:0] reg_wr_addr;
    logic [3:0] reg_wr_data;
    logic [1:0] op_mode;
    logic       out_hiz, out_std, data_fmt, serial_mode;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    conv_ctrl_select uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_csel    (pin_csel),
        .pin_sdata   (pin_sdata),
        .pin_sclk    (pin_sclk),
        .pin_pwd     (pin_pwd),
        .pin_oe      (pin_oe),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .op_mode     (op_mode),
        .out_hiz     (out_hiz),
        .out_std     (out_std),
        .data_fmt    (data_fmt),
        .serial_mode (serial_mode)
    );

    // {pwd, oe, sdata, sclk, exp_mode[1:0], exp_hiz, exp_std, exp_fmt}
    localparam logic [8:0] VEC [8] = '{
        9'b0000_00_000,
        9'b0100_00_100,
        9'b1000_01_100,
        9'b1100_10_100,
        9'b0010_00_010,
        9'b0001_00_001,
        9'b1011_01_111,
        9'b0111_00_111
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_outs(input string req, input logic [1:0] m,
                              input logic h, input logic s, input logic f);
        check(req, "op_mode",  {2'b0, op_mode},  {2'b0, m});
        check(req, "out_hiz",  {3'b0, out_hiz},  {3'b0, h});
        check(req, "out_std",  {3'b0, out_std},  {3'b0, s});
        check(req, "data_fmt", {3'b0, data_fmt}, {3'b0, f});
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [3:0] d);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        tick(1);
        reg_wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pin_csel = 1'b1; pin_sdata = 1'b0; pin_sclk = 1'b0;
        pin_pwd = 1'b0; pin_oe = 1'b0;
        reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0;
        tick(3);
        check("R1", "serial_mode in reset", {3'b0, serial_mode}, 4'h0);
        rst_n = 1'b1;
        tick(3);
        check("R1", "serial_mode after reset", {3'b0, serial_mode}, 4'h0);

        // Pin-mode table: R2 decode, R3 standard pin, R4 format pin, R5 stay.
        for (int i = 0; i < 8; i++) begin
            {pin_pwd, pin_oe, pin_sdata, pin_sclk} = VEC[i][8:5];
            tick(3);
            check_outs("R2/R3/R4", VEC[i][4:3], VEC[i][2], VEC[i][1], VEC[i][0]);
            check("R5", "stay pin while cs high", {3'b0, serial_mode}, 4'h0);
        end

        // R8: writes in pin mode have no effect.
        {pin_pwd, pin_oe, pin_sdata, pin_sclk} = 4'b0000;
        tick(3);
        reg_write(4'h0, 4'hE);
        tick(2);
        check_outs("R8", 2'b00, 1'b0, 1'b0, 1'b0);

        // R5/R7: switch with the data line high.
        pin_csel = 1'b0; pin_sdata = 1'b1;
        tick(2);
        check("R5", "not yet serial after 2 edges", {3'b0, serial_mode}, 4'h0);
        tick(1);
        check("R5", "serial after 3 edges", {3'b0, serial_mode}, 4'h1);
        check("R7", "std latched high", {3'b0, out_std}, 4'h1);
        check_outs("R10", 2'b00, 1'b0, 1'b1, 1'b0);

        // R6/R7/R12: chip-select activity and pin changes after the switch.
        pin_sdata = 1'b0; pin_csel = 1'b1;
        tick(3);
        pin_csel = 1'b0; pin_pwd = 1'b1; pin_oe = 1'b1; pin_sclk = 1'b1;
        tick(5);
        check("R6", "stays serial", {3'b0, serial_mode}, 4'h1);
        check("R7", "std holds after data change", {3'b0, out_std}, 4'h1);
        check_outs("R12", 2'b00, 1'b0, 1'b1, 1'b0);

        // R9: serial register writes.
        reg_write(4'h0, 4'h1);
        check_outs("R9", 2'b01, 1'b1, 1'b1, 1'b0);
        reg_write(4'h1, 4'h0);
        check_outs("R9", 2'b01, 1'b1, 1'b1, 1'b0);
        reg_write(4'h0, 4'h8);
        check_outs("R9", 2'b00, 1'b0, 1'b1, 1'b1);
        reg_write(4'h0, 4'h4);
        check_outs("R9", 2'b00, 1'b1, 1'b1, 1'b0);
        reg_write(4'h0, 4'h3);
        check_outs("R9", 2'b10, 1'b1, 1'b1, 1'b0);
        reg_write(4'h0, 4'h2);
        check_outs("R9", 2'b10, 1'b1, 1'b1, 1'b0);
        check("R7", "std unaffected by writes", {3'b0, out_std}, 4'h1);

        // R11: reset returns to pin mode; pins pwd=1 oe=1 sclk=1 sdata=0.
        pin_csel = 1'b1;
        tick(3);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(3);
        check("R11", "pin mode after reset", {3'b0, serial_mode}, 4'h0);
        check_outs("R11", 2'b10, 1'b1, 1'b0, 1'b1);

        // R7: second switch with the data line low selects CMOS.
        pin_csel = 1'b0;
        tick(3);
        check("R5", "serial again", {3'b0, serial_mode}, 4'h1);
        check("R7", "std latched low", {3'b0, out_std}, 4'h0);
        pin_sdata = 1'b1;
        tick(3);
        check_outs("R10", 2'b00, 1'b0, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule